// File: doc/BRIEF.md
# I2C Slave Address-Match Receiver

This block is the receive and addressing half of an I2C target. It watches the bus for START and STOP conditions and collects each byte one bit at a time, MSB first. It then decides whether the byte is meant for this device by comparing it with a compare register that the host programs. Both 7-bit and 10-bit addressing are supported. The raw bus lines first pass through a two-flop synchronizer in the system clock domain. Every event is then derived from the synchronized copies.

When a byte is accepted, the block acknowledges it by pulling SDA low. It copies the byte into a one-entry receive buffer and raises a sticky interrupt flag. If the host has not yet emptied the buffer, or a previous overflow is still pending, the byte is refused and the buffer keeps its old value. The interrupt still fires so that the host notices the loss. In 10-bit mode the address arrives in two passes. After each address byte the block holds SCL low until the host has rewritten the compare register with the value needed next.

The host side is a small register port with a combinational read path:
- Address 0 is control: bit0 enable, bit1 10-bit mode, bit2 interrupt on START/STOP.
- Address 1 is the compare register.
- Address 2 is the receive buffer. Reading it empties the buffer.
- Address 3 is status: bit0 buffer full, bit1 overflow, bit2 interrupt, bit3 address-update pending, bit4 R/W bit of the last matched address byte. Bits 1 and 2 are cleared by writing 1.

Both bus outputs are open-drain enables: 1 pulls the line low, 0 releases it.

Top module: `i2c_addr_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception. A STOP (SDA rising while SCL is high) returns the block to idle. Bytes clocked after a STOP and before the next START are not acknowledged and change no status.
- R2: In 7-bit mode, bits are sampled on SCL rising edges, MSB first. After the eighth bit, byte bits 7:1 are compared with compare-register bits 7:1. On a mismatch there is no ACK, no buffer load and no interrupt, and every further byte up to the next START or STOP is ignored.
- R3: An accepted byte, whether address or data, is acknowledged: SDA is pulled low from the eighth SCL falling edge until the ninth. The byte is copied into the receive buffer and status bit0 is set. Status bit2 is set at the ninth SCL falling edge.
- R4: When a matched byte completes while status bit0 or bit1 is already set, there is no ACK and the receive buffer is unchanged, but status bit2 is still set. Status bit1 is set if bit0 was set. Later bytes of that transfer are ignored.
- R5: Status bit0 is cleared only by reading address 2. Status bits 1 and 2 are cleared only by writing 1 to them at address 3.
- R6: In 10-bit mode, a first byte of the form 11110,A9,A8,0 whose bits 7:1 equal compare bits 7:1 is accepted. Status bit3 is then set and SCL is held low. The next byte must equal all eight compare bits to be accepted, after which status bit3 is set and SCL is held low again. Data bytes follow.
- R7: Writing the compare register clears status bit3 and releases SCL.
- R8: In 10-bit mode, a header with R/W=1 is acknowledged only if a full two-byte match has occurred since the last STOP. A repeated START followed by that header therefore needs no low address byte.
- R9: With control bit2 set, every START and every STOP sets status bit2. With control bit2 clear, neither does.
- R10: With control bit0 clear, nothing is acknowledged, SCL is never held and nothing is loaded. After reset every register reads 0 and both outputs are released.
- R11: Status bit4 holds the R/W bit (byte bit0) of the last address byte that matched. A 7-bit address with R/W=1 is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects) |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Sticky interrupt flag |

## Verification
Some properties are checked by assertions on every cycle:
- SDA is only pulled low while SCL is low.
- A buffer load never happens while the full or overflow flag is set.
- The full, overflow and interrupt flags stay set until their own clear action.
- A compare-register write releases the clock stretch on the next cycle.

Other behaviours can only be shown by the bench's bus scenarios:
- The address comparison itself and what is ignored after a refusal.
- The two-pass 10-bit sequence and the read-header shortcut after a repeated START.
- The START/STOP interrupt option.
- The interplay of overflow with the buffer across random traffic.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam logic [4:0] HDR10 = 5'b11110;

    localparam logic [1:0] RA_CTRL  = 2'd0;
    localparam logic [1:0] RA_MATCH = 2'd1;
    localparam logic [1:0] RA_RXBUF = 2'd2;
    localparam logic [1:0] RA_STAT  = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_LO,
        ST_DATA,
        ST_SKIP
    } rx_state_e;

    // control register, bit0 = enable
    typedef struct packed {
        logic ss_irq;
        logic ten;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    // outcome of the eighth-bit decision
    typedef struct packed {
        logic ack;
        logic load;
        logic ovf_set;
        logic irq;
        logic ua;
    } verdict_t;

    function automatic logic is_hdr10(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1 -: 5] == HDR10;
    endfunction

    function automatic verdict_t judge(input logic hit, input logic bf,
                                       input logic ovf, input logic want_ua);
        verdict_t v;
        v         = '0;
        if (hit) begin
            v.ack     = !bf && !ovf;
            v.load    = !bf && !ovf;
            v.ovf_set = bf;
            v.irq     = 1'b1;
            v.ua      = want_ua && !bf && !ovf;
        end
        return v;
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
    import i2cs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output logic    sda_s,
    output bus_ev_t ev
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;
    logic              scl_s;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) q <= '1;
            else     q <= {q[STAGES-2:0], raw[g]};
        end
        assign synced[g] = q[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    assign scl_s = synced[0];
    assign sda_s = synced[1];

    always_comb begin
        ev.rise  = scl_s && !prev[0];
        ev.fall  = !scl_s && prev[0];
        ev.start = scl_s && prev[0] && prev[1] && !sda_s;
        ev.stop  = scl_s && prev[0] && !prev[1] && sda_s;
    end

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              ten,
    input  bus_ev_t           ev,
    input  logic              sda_s,
    input  logic [BYTE_W-1:0] match,
    input  logic              bf,
    input  logic              ovf,
    output logic              ack_drv,
    output logic              ld_p,
    output logic [BYTE_W-1:0] ld_byte,
    output logic              ovf_p,
    output logic              irq_p,
    output logic              ua_p,
    output logic              rw_p,
    output logic              rw_v,
    output logic              cond_p
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    rx_state_e         state, nxt;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              in_ack, pend_irq, pend_ua, hi_ok;

    logic      hit, want_ua, is_addr, lo_hit, hdr_hit;
    rx_state_e goal;
    verdict_t  v;

    assign hdr_hit = is_hdr10(sh) && (sh[BYTE_W-1:1] == match[BYTE_W-1:1]);

    always_comb begin
        hit     = 1'b0;
        want_ua = 1'b0;
        is_addr = 1'b0;
        lo_hit  = 1'b0;
        goal    = ST_SKIP;
        case (state)
            ST_ADDR: begin
                is_addr = 1'b1;
                if (!ten) begin
                    hit  = sh[BYTE_W-1:1] == match[BYTE_W-1:1];
                    goal = sh[0] ? ST_SKIP : ST_DATA;
                end else if (!sh[0]) begin
                    hit     = hdr_hit;
                    want_ua = 1'b1;
                    goal    = ST_ADDR_LO;
                end else begin
                    hit  = hdr_hit && hi_ok;
                    goal = ST_SKIP;
                end
            end
            ST_ADDR_LO: begin
                hit     = sh == match;
                want_ua = 1'b1;
                lo_hit  = 1'b1;
                goal    = ST_DATA;
            end
            ST_DATA: begin
                hit  = 1'b1;
                goal = ST_DATA;
            end
            default: ;
        endcase
        v = judge(hit, bf, ovf, want_ua);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            nxt      <= ST_IDLE;
            sh       <= '0;
            cnt      <= '0;
            in_ack   <= 1'b0;
            ack_drv  <= 1'b0;
            pend_irq <= 1'b0;
            pend_ua  <= 1'b0;
            hi_ok    <= 1'b0;
            ld_p     <= 1'b0;
            ld_byte  <= '0;
            ovf_p    <= 1'b0;
            irq_p    <= 1'b0;
            ua_p     <= 1'b0;
            rw_p     <= 1'b0;
            rw_v     <= 1'b0;
            cond_p   <= 1'b0;
        end else begin
            ld_p   <= 1'b0;
            ovf_p  <= 1'b0;
            irq_p  <= 1'b0;
            ua_p   <= 1'b0;
            rw_p   <= 1'b0;
            cond_p <= 1'b0;
            if (!en) begin
                state    <= ST_IDLE;
                in_ack   <= 1'b0;
                ack_drv  <= 1'b0;
                pend_irq <= 1'b0;
                pend_ua  <= 1'b0;
                hi_ok    <= 1'b0;
                cnt      <= '0;
            end else if (ev.start || ev.stop) begin
                state    <= ev.start ? ST_ADDR : ST_IDLE;
                cnt      <= '0;
                in_ack   <= 1'b0;
                ack_drv  <= 1'b0;
                pend_irq <= 1'b0;
                pend_ua  <= 1'b0;
                cond_p   <= 1'b1;
                if (ev.stop) hi_ok <= 1'b0;
            end else if (in_ack) begin
                if (ev.fall) begin
                    in_ack  <= 1'b0;
                    ack_drv <= 1'b0;
                    irq_p   <= pend_irq;
                    ua_p    <= pend_ua;
                    state   <= nxt;
                    cnt     <= '0;
                end
            end else if (state == ST_ADDR || state == ST_ADDR_LO || state == ST_DATA) begin
                if (ev.rise && cnt < LAST_BIT) begin
                    sh  <= {sh[BYTE_W-2:0], sda_s};
                    cnt <= cnt + 1'b1;
                end else if (ev.fall && cnt == LAST_BIT) begin
                    in_ack   <= 1'b1;
                    ack_drv  <= v.ack;
                    ld_p     <= v.load;
                    ld_byte  <= sh;
                    ovf_p    <= v.ovf_set;
                    pend_irq <= v.irq;
                    pend_ua  <= v.ua;
                    nxt      <= v.ack ? goal : ST_SKIP;
                    if (is_addr && hit) begin
                        rw_p <= 1'b1;
                        rw_v <= sh[0];
                    end
                    if (lo_hit && v.ack) hi_ok <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              ld_p,
    input  logic [BYTE_W-1:0] ld_byte,
    input  logic              ovf_p,
    input  logic              irq_p,
    input  logic              ua_p,
    input  logic              rw_p,
    input  logic              rw_v,
    input  logic              cond_p,
    output logic              ctrl_en,
    output logic              ctrl_ten,
    output logic [BYTE_W-1:0] match,
    output logic              bf,
    output logic              ovf,
    output logic              irq_f,
    output logic              ua
);
    ctrl_t             ctrl;
    logic [BYTE_W-1:0] rxbuf;
    logic              rw;
    logic              wr_ctrl, wr_match, wr_stat, rd_buf;

    assign wr_ctrl  = reg_wr && reg_addr == RA_CTRL;
    assign wr_match = reg_wr && reg_addr == RA_MATCH;
    assign wr_stat  = reg_wr && reg_addr == RA_STAT;
    assign rd_buf   = reg_rd && reg_addr == RA_RXBUF;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            match <= '0;
            rxbuf <= '0;
            bf    <= 1'b0;
            ovf   <= 1'b0;
            irq_f <= 1'b0;
            ua    <= 1'b0;
            rw    <= 1'b0;
        end else begin
            if (wr_ctrl)  ctrl  <= ctrl_t'(reg_wdata[2:0]);
            if (wr_match) match <= reg_wdata;
            if (ld_p)     rxbuf <= ld_byte;

            if (ld_p)        bf <= 1'b1;
            else if (rd_buf) bf <= 1'b0;

            if (ovf_p)                        ovf <= 1'b1;
            else if (wr_stat && reg_wdata[1]) ovf <= 1'b0;

            if (irq_p || (cond_p && ctrl.ss_irq)) irq_f <= 1'b1;
            else if (wr_stat && reg_wdata[2])     irq_f <= 1'b0;

            if (ua_p)          ua <= 1'b1;
            else if (wr_match) ua <= 1'b0;

            if (rw_p) rw <= rw_v;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = {5'b0, ctrl};
            RA_MATCH: reg_rdata = match;
            RA_RXBUF: reg_rdata = rxbuf;
            default:  reg_rdata = {3'b0, rw, ua, irq_f, ovf, bf};
        endcase
    end

    assign ctrl_en  = ctrl.en;
    assign ctrl_ten = ctrl.ten;

endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq
);
    bus_ev_t           ev;
    logic              sda_s;
    logic              ctrl_en, ctrl_ten;
    logic [BYTE_W-1:0] match, ld_byte;
    logic              bf, ovf, irq_f, ua;
    logic              ld_p, ovf_p, irq_p, ua_p, rw_p, rw_v, cond_p, ack_drv;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .sda_s  (sda_s),
        .ev     (ev)
    );

    i2cs_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_en),
        .ten     (ctrl_ten),
        .ev      (ev),
        .sda_s   (sda_s),
        .match   (match),
        .bf      (bf),
        .ovf     (ovf),
        .ack_drv (ack_drv),
        .ld_p    (ld_p),
        .ld_byte (ld_byte),
        .ovf_p   (ovf_p),
        .irq_p   (irq_p),
        .ua_p    (ua_p),
        .rw_p    (rw_p),
        .rw_v    (rw_v),
        .cond_p  (cond_p)
    );

    i2cs_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ld_p      (ld_p),
        .ld_byte   (ld_byte),
        .ovf_p     (ovf_p),
        .irq_p     (irq_p),
        .ua_p      (ua_p),
        .rw_p      (rw_p),
        .rw_v      (rw_v),
        .cond_p    (cond_p),
        .ctrl_en   (ctrl_en),
        .ctrl_ten  (ctrl_ten),
        .match     (match),
        .bf        (bf),
        .ovf       (ovf),
        .irq_f     (irq_f),
        .ua        (ua)
    );

    assign sda_oe = ack_drv;
    assign scl_oe = ua && ctrl_en;
    assign irq    = irq_f;

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
    input logic       clk,
    input logic       rst,
    input logic       scl_in,
    input logic       sda_oe,
    input logic       scl_oe,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic [1:0] wbits,
    input logic       ld_p,
    input logic       ua_p,
    input logic       bf,
    input logic       ovf,
    input logic       irq_f
);
    // R3: ACK drive only begins while the clock line is low
    p_ack_scl_low_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_in);

    // R4: no load into a full or overflowed buffer
    p_no_load_full_r4: assert property (@(posedge clk) disable iff (rst)
        ld_p |-> (!bf && !ovf));

    // R5: overflow sticks until write-one-to-clear
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (ovf && !(reg_wr && reg_addr == 2'd3 && wbits[0])) |=> ovf);

    // R5: buffer-full sticks until the buffer is read
    p_bf_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (bf && !(reg_rd && reg_addr == 2'd2)) |=> bf);

    // R5: interrupt flag sticks until write-one-to-clear
    p_irq_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (irq_f && !(reg_wr && reg_addr == 2'd3 && wbits[1])) |=> irq_f);

    // R7: compare register write releases the stretch
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && !ua_p) |=> !scl_oe);

endmodule

bind i2c_addr_slave i2cs_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .wbits    (reg_wdata[2:1]),
    .ld_p     (ld_p),
    .ua_p     (ua_p),
    .bf       (bf),
    .ovf      (ovf),
    .irq_f    (irq_f)
);

// File: tb/i2c_addr_slave_bench.sv
`timescale 1ns/1ps
module i2c_addr_slave_bench;
    localparam int Q     = 10;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       scl_bus, sda_bus;
    logic       scl_oe, sda_oe, irq;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0, reg_rdata;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic done = 1'b0;

    logic       m_bf = 0, m_ovf = 0, m_irq = 0, m_rw = 0;
    logic [7:0] m_buf = 0, cur_match = 0;

    always #2.5 clk = ~clk;

    assign scl_bus = m_scl & ~scl_oe;
    assign sda_bus = m_sda & ~sda_oe;

    i2c_addr_slave u_i2c_addr_slave (
        .clk(clk), .rst(rst), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        tick(1);
        reg_rd = 1'b0;
    endtask

    task automatic wait_high;
        m_scl = 1'b1;
        tick(1);
        while (!scl_bus) tick(1);
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; tick(Q);
        wait_high; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0; tick(Q);
        wait_high; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            wait_high; tick(2 * Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        wait_high; tick(Q);
        ack = ~sda_bus;
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    // bench model of one matched byte (R3, R4)
    task automatic model_byte(input logic [7:0] b, output logic ack);
        ack = !m_bf && !m_ovf;
        if (m_bf) m_ovf = 1'b1;
        if (ack) begin m_buf = b; m_bf = 1'b1; end
        m_irq = 1'b1;
    endtask

    function automatic logic hit7(input logic [7:0] b, input logic [7:0] m);
        return b[7:1] == m[7:1];
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == LIMIT && !done) begin
            n_bad++;
            $display("FAIL watchdog R1 act=%0d exp<%0d", cyc, LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       a;
        void'($urandom(32'h5EED1234));
        tick(4);
        rst = 1'b0;
        tick(2);

        // reset state
        reg_read(2'd3, d); check("R10 reset status", d, 8'h00);
        reg_read(2'd0, d); check("R10 reset ctrl", d, 8'h00);
        check("R10 reset oe", {scl_oe, sda_oe}, 2'b00);

        // disabled block
        reg_write(2'd1, 8'h74);
        i2c_start; send_byte(8'h74, a); check("R10 no ack when off", a, 1'b0);
        i2c_stop;
        reg_read(2'd3, d); check("R10 status off", d, 8'h00);

        // 7-bit write transfer
        reg_write(2'd0, 8'h01);
        i2c_start; send_byte(8'h74, a); check("R2 addr ack", a, 1'b1);
        reg_read(2'd3, d); check("R3 status after addr", d, 8'h05);
        check("R3 irq pin", irq, 1'b1);
        reg_read(2'd2, d); check("R3 rxbuf addr", d, 8'h74);
        reg_read(2'd3, d); check("R5 read clears bf only", d, 8'h04);
        send_byte(8'hC3, a); check("R3 data ack", a, 1'b1);
        send_byte(8'h11, a); check("R4 nack when full", a, 1'b0);
        reg_read(2'd3, d); check("R4 ovf and irq", d, 8'h07);
        reg_write(2'd3, 8'h04);
        reg_read(2'd3, d); check("R5 irq cleared", d, 8'h03);
        send_byte(8'h22, a); check("R4 ignored after nack", a, 1'b0);
        reg_read(2'd3, d); check("R4 no irq when ignored", d, 8'h03);
        reg_read(2'd2, d); check("R4 rxbuf kept", d, 8'hC3);
        reg_read(2'd3, d); check("R5 ovf stays", d, 8'h02);
        reg_write(2'd3, 8'h02);
        reg_read(2'd3, d); check("R5 ovf cleared", d, 8'h00);
        i2c_stop;

        // R1: byte after stop without start
        m_scl = 1'b0; tick(Q);
        send_byte(8'h74, a); check("R1 no ack without start", a, 1'b0);
        i2c_stop;
        reg_read(2'd3, d); check("R1 status idle", d, 8'h00);

        // R2: mismatch
        i2c_start; send_byte(8'h76, a); check("R2 mismatch nack", a, 1'b0);
        send_byte(8'h74, a); check("R2 later byte ignored", a, 1'b0);
        i2c_stop;
        reg_read(2'd3, d); check("R2 no irq", d, 8'h00);

        // R11: read address
        i2c_start; send_byte(8'h75, a); check("R11 read addr ack", a, 1'b1);
        i2c_stop;
        reg_read(2'd3, d); check("R11 rw bit", d, 8'h15);
        reg_read(2'd2, d); check("R11 rxbuf", d, 8'h75);
        reg_write(2'd3, 8'h04);

        // R9: start/stop interrupts
        reg_write(2'd0, 8'h05);
        i2c_start;
        reg_read(2'd3, d); check("R9 start irq", d[2], 1'b1);
        reg_write(2'd3, 8'h04);
        i2c_stop;
        reg_read(2'd3, d); check("R9 stop irq", d[2], 1'b1);
        reg_write(2'd3, 8'h04);
        reg_write(2'd0, 8'h01);
        i2c_start; i2c_stop;
        reg_read(2'd3, d); check("R9 off no irq", d[2], 1'b0);

        // R6/R7/R8: 10-bit address 0x2D5, header 0xF4
        reg_write(2'd0, 8'h03);
        reg_write(2'd1, 8'hF4);
        i2c_start; send_byte(8'hF4, a); check("R6 header ack", a, 1'b1);
        tick(4); check("R6 stretch after header", scl_oe, 1'b1);
        reg_read(2'd3, d); check("R6 ua set", d, 8'h0D);
        reg_read(2'd2, d); check("R6 rxbuf header", d, 8'hF4);
        reg_write(2'd1, 8'hD5);
        tick(1); check("R7 release", scl_oe, 1'b0);
        reg_read(2'd3, d); check("R7 ua cleared", d, 8'h04);
        reg_write(2'd3, 8'h04);
        send_byte(8'hD5, a); check("R6 low byte ack", a, 1'b1);
        tick(4); check("R6 stretch after low", scl_oe, 1'b1);
        reg_write(2'd1, 8'hF4);
        tick(1); check("R7 release 2", scl_oe, 1'b0);
        reg_read(2'd2, d); check("R6 rxbuf low", d, 8'hD5);
        send_byte(8'h5C, a); check("R6 data ack", a, 1'b1);
        reg_read(2'd2, d); check("R6 rxbuf data", d, 8'h5C);
        i2c_start; send_byte(8'hF5, a); check("R8 repeated read header ack", a, 1'b1);
        reg_read(2'd3, d); check("R8 rw set", d[4], 1'b1);
        i2c_stop;
        reg_read(2'd2, d);
        reg_write(2'd3, 8'h06);
        i2c_start; send_byte(8'hF5, a); check("R8 read header without match", a, 1'b0);
        i2c_stop;
        i2c_start; send_byte(8'hF4, a); check("R6 header again", a, 1'b1);
        reg_read(2'd2, d);
        reg_write(2'd1, 8'hD4);
        send_byte(8'hD5, a); check("R6 wrong low nack", a, 1'b0);
        i2c_stop;

        // random 7-bit traffic
        reg_write(2'd0, 8'h01);
        cur_match = 8'($urandom);
        reg_write(2'd1, cur_match);
        reg_read(2'd2, d);
        reg_write(2'd3, 8'h06);
        m_bf = 0; m_ovf = 0; m_irq = 0; m_buf = d;
        reg_read(2'd3, d); m_rw = d[4];
        for (int t = 0; t < 24; t++) begin
            logic [7:0] ab;
            logic       ea, hit;
            int         nd;
            reg_write(2'd3, 8'h06); m_irq = 0; m_ovf = 0;
            ab = 8'($urandom);
            if ($urandom % 10 < 6) ab[7:1] = cur_match[7:1];
            nd = $urandom % 4;
            i2c_start; send_byte(ab, a);
            hit = hit7(ab, cur_match);
            ea  = 1'b0;
            if (hit) begin m_rw = ab[0]; model_byte(ab, ea); end
            check("R2 random addr", a, ea);
            if (ea && !ab[0]) begin
                for (int k = 0; k < nd; k++) begin
                    logic [7:0] db;
                    logic       da, eda;
                    db = 8'($urandom);
                    if ($urandom % 2 == 1) begin
                        reg_read(2'd2, d); check("R5 random rxbuf", d, m_buf); m_bf = 0;
                    end
                    send_byte(db, da); model_byte(db, eda);
                    check("R4 random data", da, eda);
                    if (!eda) break;
                end
            end
            i2c_stop;
            reg_read(2'd3, d);
            check("R3 random status", d, {3'b0, m_rw, 1'b0, m_irq, m_ovf, m_bf});
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule